// File: doc/BRIEF.md
# Even/Odd Split Parallel Multiplier

This block multiplies two unsigned N-bit operands into a full 2N-bit product. N is 32 by default. Each operand is first split into two masked copies. One copy keeps only the bits at even positions and the other keeps only the bits at odd positions. Every other position in a copy is zero.

The four cross pairs (even·even, even·odd, odd·even, odd·odd) give rows of partial products. Each row is placed at its true weight, and all rows go into a single carry-save tree. Every level of the tree turns groups of three vectors into two using full adders. No carry ripples inside the tree. At the end, one carry-lookahead adder resolves the two remaining vectors. That adder is built from 4-bit groups whose generate and propagate terms are merged through a log-depth prefix network.

An optional output register, selected by a parameter and on by default, is placed after the adder for timing.

Top module: `eo_split_mul`

## Requirements
- R1: For every pair of unsigned operands, `prod_o` equals the exact 2N-bit product `a_i * b_i`, with no truncation.
- R2: Each operand is split into an even-position copy (bits 0, 2, 4, ...) and an odd-position copy (bits 1, 3, 5, ...). All other positions of each copy are zero, so the two copies add back to the operand.
- R3: The four cross sub-products are aligned by their true weight. Operands made only of the alternating patterns 0x5555_5555 and 0xAAAA_AAAA, in each of the four pairings, give the exact product.
- R4: The partial products are reduced by levels of 3-to-2 full-adder compression, with no carry propagation. The two vectors left by the tree add up to `a_i * b_i` modulo 2^(2N).
- R5: The final adder uses 4-bit lookahead groups that are combined hierarchically. Its sum equals the exact sum of the two tree vectors, including for the all-ones × all-ones case, which carries along the full width.
- R6: With `OUT_REG` = 1, `prod_o` shows the product of the operands sampled at the previous rising edge of `clk`. It holds that value when the operands change between edges.
- R7: An active-low asynchronous `rst_n` forces `prod_o` to zero while it is low, whatever the operands are.
- R8: A zero operand gives a zero product, and an operand of 1 returns the other operand unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock for the optional output register |
| rst_n | input | 1 | Asynchronous active-low clear of the output register |
| a_i | input | N | Unsigned multiplicand |
| b_i | input | N | Unsigned multiplier |
| prod_o | output | 2N | Unsigned 2N-bit product |

## Verification
With the output register present, each product is due exactly one rising edge after its operands are applied.

The driver applies operands on the falling edge and queues the expected product. The monitor takes one item from the queue 1 ns after each rising edge, so it compares each result in the cycle in which that result first appears.

One extra probe changes the operands on a falling edge and reads the output 1 ns later. At that point the output must still hold the previous product. This confirms that nothing passes through before the edge.

During reset, the output is sampled on falling edges while non-zero operands are applied.

// File: rtl/eo_split_mul.sv
`timescale 1ns/1ps
module eo_split_mul #(
  parameter int N       = 32,
  parameter bit OUT_REG = 1'b1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [N-1:0]     a_i,
  input  logic [N-1:0]     b_i,
  output logic [2*N-1:0]   prod_o
);
  localparam int W    = 2 * N;
  localparam int ROWS = 2 * N;
  localparam int WP   = ((W + 3) / 4) * 4;
  localparam int NG   = WP / 4;
  localparam int LG   = (NG > 1) ? $clog2(NG) : 0;

  function automatic int tree_depth();
    int n = ROWS;
    int d = 0;
    while (n > 2) begin
      n = (n / 3) * 2 + (n % 3);
      d++;
    end
    return d;
  endfunction

  localparam int LEVELS = tree_depth();

  function automatic logic [N-1:0] pos_mask(input bit odd);
    logic [N-1:0] m;
    for (int i = 0; i < N; i++) m[i] = ((i % 2) == 1) == odd;
    return m;
  endfunction

  localparam logic [N-1:0] EV_MASK = pos_mask(1'b0);
  localparam logic [N-1:0] OD_MASK = pos_mask(1'b1);

  logic [N-1:0] a_ev, a_od;
  assign a_ev = a_i & EV_MASK;
  assign a_od = a_i & OD_MASK;

  // R2
  always_comb begin
    if (!$isunknown(a_i)) begin
      split_sum_chk: assert ((W'(a_ev) + W'(a_od)) == W'(a_i) && (a_ev & a_od) == '0);
    end
  end

  logic [W-1:0] pp [ROWS];

  generate
    for (genvar j = 0; j < N; j++) begin : g_rows
      assign pp[2*j]   = (W'(a_ev) << j) & {W{b_i[j]}};
      assign pp[2*j+1] = (W'(a_od) << j) & {W{b_i[j]}};
    end
  endgenerate

  logic [W-1:0] vec_s, vec_c;

  always_comb begin
    logic [W-1:0] cur [ROWS];
    logic [W-1:0] nxt [ROWS];
    logic [W-1:0] x, y, z;
    int n;
    cur = pp;
    n = ROWS;
    for (int l = 0; l < LEVELS; l++) begin
      nxt = '{default: '0};
      for (int g = 0; g < ROWS / 3; g++) begin
        if (g < n / 3) begin
          x = cur[3*g];
          y = cur[3*g+1];
          z = cur[3*g+2];
          nxt[2*g]   = x ^ y ^ z;
          nxt[2*g+1] = ((x & y) | (x & z) | (y & z)) << 1;
        end
      end
      for (int r = 0; r < 2; r++) begin
        if (r < n % 3) nxt[2*(n/3)+r] = cur[3*(n/3)+r];
      end
      cur = nxt;
      n = (n / 3) * 2 + (n % 3);
    end
    vec_s = cur[0];
    vec_c = (ROWS > 1) ? cur[1] : '0;
  end

  // R4
  always_comb begin
    if (!$isunknown({a_i, b_i})) begin
      tree_sum_chk: assert ((vec_s + vec_c) == (W'(a_i) * W'(b_i)));
    end
  end

  logic [WP-1:0] ox, oy, gen, prp, sum_w;
  logic [NG-1:0] gg, gp;
  logic [NG:0]   grp_c;

  assign ox  = WP'(vec_s);
  assign oy  = WP'(vec_c);
  assign gen = ox & oy;
  assign prp = ox ^ oy;

  generate
    for (genvar k = 0; k < NG; k++) begin : g_grp
      logic [3:0] g4, p4, c4;
      assign g4 = gen[4*k +: 4];
      assign p4 = prp[4*k +: 4];
      assign gg[k] = g4[3] | (p4[3] & g4[2]) | (p4[3] & p4[2] & g4[1])
                   | (p4[3] & p4[2] & p4[1] & g4[0]);
      assign gp[k] = &p4;
      assign c4[0] = grp_c[k];
      assign c4[1] = g4[0] | (p4[0] & grp_c[k]);
      assign c4[2] = g4[1] | (p4[1] & g4[0]) | (p4[1] & p4[0] & grp_c[k]);
      assign c4[3] = g4[2] | (p4[2] & g4[1]) | (p4[2] & p4[1] & g4[0])
                   | (p4[2] & p4[1] & p4[0] & grp_c[k]);
      assign sum_w[4*k +: 4] = p4 ^ c4;
    end
  endgenerate

  always_comb begin
    logic [NG-1:0] tg, tp, ng, np;
    tg = gg;
    tp = gp;
    for (int s = 0; s < LG; s++) begin
      ng = tg;
      np = tp;
      for (int k = 0; k < NG; k++) begin
        if (k >= (1 << s)) begin
          ng[k] = tg[k] | (tp[k] & tg[k - (1 << s)]);
          np[k] = tp[k] & tp[k - (1 << s)];
        end
      end
      tg = ng;
      tp = np;
    end
    grp_c[0] = 1'b0;
    for (int k = 1; k <= NG; k++) grp_c[k] = tg[k-1];
  end

  logic [W-1:0] cla_out;
  assign cla_out = sum_w[W-1:0];

  // R5
  always_comb begin
    if (!$isunknown({vec_s, vec_c})) begin
      cla_sum_chk: assert ({grp_c[NG], sum_w} == ((WP+1)'(ox) + (WP+1)'(oy)));
    end
  end

  generate
    if (OUT_REG) begin : g_reg
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) prod_o <= '0;
        else        prod_o <= cla_out;
      end

      // R6
      out_reg_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) |-> prod_o == (W'($past(a_i)) * W'($past(b_i))));

      // R7
      reset_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> prod_o == '0);
    end else begin : g_comb
      assign prod_o = cla_out;
    end
  endgenerate
endmodule

// File: tb/sim_eo_split_mul.sv
`timescale 1ns/1ps
module sim_eo_split_mul;
  localparam int N = 32;
  localparam int W = 2 * N;

  typedef struct {
    logic [W-1:0] exp;
    string        tag;
  } item_t;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic [N-1:0] a = '0;
  logic [N-1:0] b = '0;
  logic [W-1:0] prod;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;
  item_t sb [$];

  eo_split_mul #(.N(N), .OUT_REG(1'b1)) u0 (
    .clk(clk), .rst_n(rst_n), .a_i(a), .b_i(b), .prod_o(prod)
  );

  always #4 clk = ~clk;

  task automatic chk(input bit ok, input string tag, input logic [W-1:0] act, input logic [W-1:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic drive(input logic [N-1:0] x, input logic [N-1:0] y, input string tag);
    item_t it;
    @(negedge clk);
    a = x;
    b = y;
    it.exp = W'(x) * W'(y);
    it.tag = tag;
    sb.push_back(it);
  endtask

  always @(posedge clk) begin
    #1;
    if (rst_n && sb.size() > 0) begin
      item_t it;
      it = sb.pop_front();
      chk(prod === it.exp, it.tag, prod, it.exp);
    end
  end

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  endtask

  initial begin
    #(8 * 200000);
    errors++;
    checks++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    logic [N-1:0] ones, evp, odp;
    ones = '1;
    evp  = 32'h5555_5555;
    odp  = 32'hAAAA_AAAA;

    a = 32'd5;
    b = 32'd7;
    repeat (3) @(negedge clk);
    // R7: output held at zero during reset with non-zero operands
    chk(prod === '0, "R7", prod, '0);
    a = ones;
    b = ones;
    @(negedge clk);
    chk(prod === '0, "R7", prod, '0);
    rst_n = 1'b1;

    drive('0, ones, "R8");
    drive(32'h1234_5678, '0, "R8");
    drive(32'd1, 32'hDEAD_BEEF, "R8");
    drive(32'hCAFE_F00D, 32'd1, "R8");
    drive(ones, ones, "R5");
    drive(ones, 32'd1, "R5");
    drive(evp, evp, "R3");
    drive(odp, odp, "R3");
    drive(evp, odp, "R3");
    drive(odp, evp, "R3");
    drive(32'hFFFF_0000, 32'h0000_FFFF, "R2");
    drive(32'h8000_0001, 32'h8000_0001, "R2");
    drive(ones, 32'h7FFF_FFFF, "R4");
    drive(32'h8000_0000, 32'h8000_0000, "R4");

    // R6: the output must hold the previous product until the next edge
    begin
      item_t it;
      drive(32'd3, 32'd9, "R6");
      @(negedge clk);
      a = 32'd11;
      b = 32'd13;
      it.exp = W'(32'd11) * W'(32'd13);
      it.tag = "R6";
      sb.push_back(it);
      #1;
      chk(prod === W'(27), "R6", prod, W'(27));
    end

    for (int i = 0; i < 10000; i++) begin
      drive($urandom, $urandom, "R1");
    end

    repeat (4) @(posedge clk);
    #2;
    finish_run();
  end
endmodule